// File: doc/BRIEF.md
# Paged Opcode Predecoder with Cycle Costs

This block sits on the fetch path of a small 8-bit processor core. It takes opcode bytes one at a time and classifies each one. The fetch unit offers only opcode bytes here. It skips the operand bytes itself, using the length that this block reports. For each instruction the block reports five things: the operation class, the addressing mode, how many operand bytes follow the opcode, the total number of clock cycles the instruction takes, and whether the opcode is illegal.

A page byte (0x9E by default) may come before an opcode. After a page byte the next opcode is decoded from a second table. In that table the high nibbles that select indexed-offset modes on the base page select stack-pointer-relative offset modes instead. The cycle count reported for such an instruction already includes the cycle spent on the page byte. The page byte produces no result of its own. The block waits for the next valid byte, however long that takes, and only then reports.

Every result is registered. A decode strobe marks the single cycle in which a new result appears. The output fields keep their values until the next result arrives.

Top module: `opcode_predecoder`

## Requirements
- R1: During and after a synchronous active-high reset, with no input yet accepted, the outputs read as follows: strobe 0, illegal 0, mode 0, operation 0, length 0, cycles 0. No page byte is pending.
- R2: A byte presented with `in_vld` high at a rising edge, and not taken as a page byte, gives `dec_vld` high for exactly the next cycle, holding that byte's result. While `in_vld` is low, `dec_vld` stays low.
- R3: With no page byte pending, a valid byte equal to `PREFIX` gives no strobe. It marks the page as pending, and the pending state lasts through any number of idle cycles until the next valid byte.
- R4: Base-page arithmetic group: a low nibble of 9, B or 4 with a high nibble from A to F. The high nibble selects the mode, length and cycles as follows (mode code, length, cycles): A = IMM (1, 1, 2), B = DIR (2, 1, 3), C = EXT (3, 2, 4), D = IX2 (4, 2, 4), E = IX1 (5, 1, 3), F = IX0 (6, 0, 2).
- R5: The low nibble of an arithmetic-group opcode selects the operation code: 9 gives ADC = 1, B gives ADD = 2, 4 gives AND = 3. This holds on both pages.
- R6: Shift group: a low nibble of 8 gives SHL = 4 and a low nibble of 7 gives SHR = 5. The high nibble selects (mode code, length, cycles) as follows: 3 = DIR (2, 1, 4), 4 = INHA (9, 0, 1), 5 = INHX (10, 0, 1), 6 = IX1 (5, 1, 4), 7 = IX0 (6, 0, 3).
- R7: The pointer-adjust bytes are decoded as follows. 0xA7 gives operation SPADD = 6 and 0xAF gives IXADD = 7. Both have mode IMM (1), length 1 and 2 cycles.
- R8: After a page byte, the arithmetic group with high nibble E gives SP1 (mode 7, length 1, 4 cycles) and with high nibble D gives SP2 (mode 8, length 2, 5 cycles). A shift-group byte with high nibble 6 gives SP1 (mode 7, length 1, 5 cycles). These counts include the page byte's cycle.
- R9: Any byte not listed for the current page, including a second page byte in a row, gives a strobe with illegal 1 and mode, operation, length and cycles all 0. Any decoded byte clears the pending page.
- R10: Between strobes, every output field keeps the value of the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Opcode byte valid |
| in_byte | input | 8 | Opcode byte |
| dec_vld | output | 1 | One-cycle strobe: new result present |
| dec_illegal | output | 1 | Opcode not recognised |
| dec_mode | output | 4 | Addressing mode code |
| dec_op | output | 3 | Operation class code |
| dec_len | output | 2 | Operand bytes after the opcode |
| dec_cycles | output | 4 | Total cycles, page byte included |

## Verification
The only hidden state is the pending-page flag, and a wrong value in it always shows on the very next strobe. A lost flag makes a paged byte decode as a base-page result, or as illegal. A stuck or spurious flag turns a plain arithmetic opcode into a stack-pointer mode with higher cycles, or makes a page byte produce a strobe. The bench follows the page state in its own model. It compares every strobe field by field in the cycle after the byte, and during idle cycles it checks that no strobe appears and that the outputs hold.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

  typedef enum logic [3:0] {
    AM_NONE = 4'd0,
    AM_IMM  = 4'd1,
    AM_DIR  = 4'd2,
    AM_EXT  = 4'd3,
    AM_IX2  = 4'd4,
    AM_IX1  = 4'd5,
    AM_IX0  = 4'd6,
    AM_SP1  = 4'd7,
    AM_SP2  = 4'd8,
    AM_INHA = 4'd9,
    AM_INHX = 4'd10
  } amode_e;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ADC   = 3'd1,
    OP_ADD   = 3'd2,
    OP_AND   = 3'd3,
    OP_SHL   = 3'd4,
    OP_SHR   = 3'd5,
    OP_SPADD = 3'd6,
    OP_IXADD = 3'd7
  } opcls_e;

  typedef enum logic [1:0] {
    GRP_NONE  = 2'd0,
    GRP_ALU   = 2'd1,
    GRP_SHIFT = 2'd2,
    GRP_PTR   = 2'd3
  } grp_e;

endpackage

// File: rtl/opdec_group.sv
module opdec_group
  import opdec_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              paged,
  input  logic [BYTE_W-1:0] opc,
  output grp_e              grp,
  output opcls_e            op
);
  localparam int NIB_W = BYTE_W / 2;

  logic [NIB_W-1:0] hi;
  logic [NIB_W-1:0] lo;
  logic             alu_lo;
  logic             shf_lo;

  assign hi = opc[BYTE_W-1:NIB_W];
  assign lo = opc[NIB_W-1:0];

  assign alu_lo = (lo == NIB_W'(4'h9)) || (lo == NIB_W'(4'hB)) || (lo == NIB_W'(4'h4));
  assign shf_lo = (lo == NIB_W'(4'h8)) || (lo == NIB_W'(4'h7));

  always_comb begin
    grp = GRP_NONE;
    op  = OP_NONE;
    if (!paged) begin
      if (opc == BYTE_W'(8'hA7)) begin
        grp = GRP_PTR;
        op  = OP_SPADD;
      end else if (opc == BYTE_W'(8'hAF)) begin
        grp = GRP_PTR;
        op  = OP_IXADD;
      end else if (alu_lo && hi >= NIB_W'(4'hA)) begin
        grp = GRP_ALU;
      end else if (shf_lo && hi >= NIB_W'(4'h3) && hi <= NIB_W'(4'h7)) begin
        grp = GRP_SHIFT;
      end
    end else begin
      if (alu_lo && (hi == NIB_W'(4'hD) || hi == NIB_W'(4'hE))) begin
        grp = GRP_ALU;
      end else if (shf_lo && hi == NIB_W'(4'h6)) begin
        grp = GRP_SHIFT;
      end
    end

    case (grp)
      GRP_ALU: begin
        if (lo == NIB_W'(4'h9))      op = OP_ADC;
        else if (lo == NIB_W'(4'hB)) op = OP_ADD;
        else                         op = OP_AND;
      end
      GRP_SHIFT: op = (lo == NIB_W'(4'h8)) ? OP_SHL : OP_SHR;
      default: ;
    endcase
  end

endmodule

// File: rtl/opdec_mode.sv
module opdec_mode
  import opdec_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             paged,
  input  grp_e             grp,
  input  logic [NIB_W-1:0] hi,
  output amode_e           mode
);

  always_comb begin
    mode = AM_NONE;
    unique case (grp)
      GRP_PTR: mode = AM_IMM;
      GRP_ALU: begin
        if (paged) begin
          mode = (hi == NIB_W'(4'hE)) ? AM_SP1 : AM_SP2;
        end else begin
          case (hi)
            NIB_W'(4'hA): mode = AM_IMM;
            NIB_W'(4'hB): mode = AM_DIR;
            NIB_W'(4'hC): mode = AM_EXT;
            NIB_W'(4'hD): mode = AM_IX2;
            NIB_W'(4'hE): mode = AM_IX1;
            default:      mode = AM_IX0;
          endcase
        end
      end
      GRP_SHIFT: begin
        if (paged) begin
          mode = AM_SP1;
        end else begin
          case (hi)
            NIB_W'(4'h3): mode = AM_DIR;
            NIB_W'(4'h4): mode = AM_INHA;
            NIB_W'(4'h5): mode = AM_INHX;
            NIB_W'(4'h6): mode = AM_IX1;
            default:      mode = AM_IX0;
          endcase
        end
      end
      default: mode = AM_NONE;
    endcase
  end

endmodule

// File: rtl/opdec_cost.sv
module opdec_cost
  import opdec_pkg::*;
#(
  parameter int LEN_W = 2,
  parameter int CYC_W = 4
) (
  input  grp_e             grp,
  input  amode_e           mode,
  output logic [LEN_W-1:0] len,
  output logic [CYC_W-1:0] cyc
);

  // Operand length depends on the addressing mode alone.
  always_comb begin
    case (mode)
      AM_IMM, AM_DIR, AM_IX1, AM_SP1: len = LEN_W'(1);
      AM_EXT, AM_IX2, AM_SP2:         len = LEN_W'(2);
      default:                        len = LEN_W'(0);
    endcase
  end

  // The cycle cost depends on the group and the mode together.
  always_comb begin
    cyc = CYC_W'(0);
    case (grp)
      GRP_ALU: begin
        case (mode)
          AM_IMM:  cyc = CYC_W'(2);
          AM_DIR:  cyc = CYC_W'(3);
          AM_EXT:  cyc = CYC_W'(4);
          AM_IX2:  cyc = CYC_W'(4);
          AM_IX1:  cyc = CYC_W'(3);
          AM_IX0:  cyc = CYC_W'(2);
          AM_SP1:  cyc = CYC_W'(4);
          AM_SP2:  cyc = CYC_W'(5);
          default: cyc = CYC_W'(0);
        endcase
      end
      GRP_SHIFT: begin
        case (mode)
          AM_DIR:           cyc = CYC_W'(4);
          AM_INHA, AM_INHX: cyc = CYC_W'(1);
          AM_IX1:           cyc = CYC_W'(4);
          AM_IX0:           cyc = CYC_W'(3);
          AM_SP1:           cyc = CYC_W'(5);
          default:          cyc = CYC_W'(0);
        endcase
      end
      GRP_PTR: cyc = CYC_W'(2);
      default: cyc = CYC_W'(0);
    endcase
  end

endmodule

// File: rtl/opcode_predecoder.sv
module opcode_predecoder
  import opdec_pkg::*;
#(
  parameter int          BYTE_W = 8,
  parameter int          LEN_W  = 2,
  parameter int          CYC_W  = 4,
  parameter logic [7:0]  PREFIX = 8'h9E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              dec_vld,
  output logic              dec_illegal,
  output logic [3:0]        dec_mode,
  output logic [2:0]        dec_op,
  output logic [LEN_W-1:0]  dec_len,
  output logic [CYC_W-1:0]  dec_cycles
);
  localparam int NIB_W = BYTE_W / 2;

  logic             pend_q;
  logic             is_pfx;
  grp_e             grp;
  opcls_e           op;
  amode_e           mode;
  logic [LEN_W-1:0] len;
  logic [CYC_W-1:0] cyc;
  logic             bad;

  assign is_pfx = (in_byte == BYTE_W'(PREFIX));

  opdec_group #(.BYTE_W(BYTE_W)) u_group (
    .paged (pend_q),
    .opc   (in_byte),
    .grp   (grp),
    .op    (op)
  );

  opdec_mode #(.NIB_W(NIB_W)) u_mode (
    .paged (pend_q),
    .grp   (grp),
    .hi    (in_byte[BYTE_W-1:NIB_W]),
    .mode  (mode)
  );

  opdec_cost #(.LEN_W(LEN_W), .CYC_W(CYC_W)) u_cost (
    .grp   (grp),
    .mode  (mode),
    .len   (len),
    .cyc   (cyc)
  );

  assign bad = (grp == GRP_NONE) || (mode == AM_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      dec_vld     <= 1'b0;
      dec_illegal <= 1'b0;
      dec_mode    <= 4'(AM_NONE);
      dec_op      <= 3'(OP_NONE);
      dec_len     <= '0;
      dec_cycles  <= '0;
    end else begin
      dec_vld <= 1'b0;
      if (in_vld) begin
        if (!pend_q && is_pfx) begin
          pend_q <= 1'b1;
        end else begin
          pend_q      <= 1'b0;
          dec_vld     <= 1'b1;
          dec_illegal <= bad;
          dec_mode    <= bad ? 4'(AM_NONE) : 4'(mode);
          dec_op      <= bad ? 3'(OP_NONE) : 3'(op);
          dec_len     <= bad ? '0 : len;
          dec_cycles  <= bad ? '0 : cyc;
        end
      end
    end
  end

endmodule

// File: rtl/opcode_predecoder_sva.sv
module opcode_predecoder_sva #(
  parameter int         BYTE_W = 8,
  parameter int         LEN_W  = 2,
  parameter int         CYC_W  = 4,
  parameter logic [7:0] PREFIX = 8'h9E
) (
  input logic              clk,
  input logic              rst,
  input logic              in_vld,
  input logic [BYTE_W-1:0] in_byte,
  input logic              pend_q,
  input logic              dec_vld,
  input logic              dec_illegal,
  input logic [3:0]        dec_mode,
  input logic [2:0]        dec_op,
  input logic [LEN_W-1:0]  dec_len,
  input logic [CYC_W-1:0]  dec_cycles
);

  p_idle_no_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !dec_vld);

  p_byte_strobes_r2: assert property (@(posedge clk) disable iff (rst)
    (in_vld && (pend_q || in_byte != BYTE_W'(PREFIX))) |=> dec_vld);

  p_prefix_silent_r3: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !pend_q && in_byte == BYTE_W'(PREFIX)) |=> (!dec_vld && pend_q));

  p_double_prefix_r9: assert property (@(posedge clk) disable iff (rst)
    (in_vld && pend_q && in_byte == BYTE_W'(PREFIX)) |=> (dec_vld && dec_illegal && !pend_q));

  p_illegal_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (dec_vld && dec_illegal) |-> (dec_mode == 4'd0 && dec_op == 3'd0 &&
                                  dec_len == '0 && dec_cycles == '0));

  p_legal_costs_r4: assert property (@(posedge clk) disable iff (rst)
    (dec_vld && !dec_illegal) |-> (dec_cycles != '0 && dec_mode != 4'd0));

  p_sp_needs_page_r8: assert property (@(posedge clk) disable iff (rst)
    (dec_vld && (dec_mode == 4'd7 || dec_mode == 4'd8)) |-> $past(pend_q));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(dec_mode) && $stable(dec_op) && $stable(dec_len) &&
                 $stable(dec_cycles) && $stable(dec_illegal)));

endmodule

bind opcode_predecoder opcode_predecoder_sva #(
  .BYTE_W(BYTE_W), .LEN_W(LEN_W), .CYC_W(CYC_W), .PREFIX(PREFIX)
) u_sva (
  .clk(clk), .rst(rst), .in_vld(in_vld), .in_byte(in_byte), .pend_q(pend_q),
  .dec_vld(dec_vld), .dec_illegal(dec_illegal), .dec_mode(dec_mode),
  .dec_op(dec_op), .dec_len(dec_len), .dec_cycles(dec_cycles)
);

// File: tb/opcode_predecoder_tb.sv
`timescale 1ns/1ps
module opcode_predecoder_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_vld = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       dec_vld, dec_illegal;
  logic [3:0] dec_mode;
  logic [2:0] dec_op;
  logic [1:0] dec_len;
  logic [3:0] dec_cycles;

  int checks = 0;
  int fails  = 0;
  bit model_pend = 1'b0;

  always #4 clk = ~clk;

  opcode_predecoder u_dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_byte(in_byte),
    .dec_vld(dec_vld), .dec_illegal(dec_illegal), .dec_mode(dec_mode),
    .dec_op(dec_op), .dec_len(dec_len), .dec_cycles(dec_cycles)
  );

  // packed result: {illegal, mode, op, len, cycles}
  function automatic logic [13:0] ref_dec(input bit pg, input logic [7:0] b);
    logic [3:0] h, l;
    logic [2:0] o;
    h = b[7:4];
    l = b[3:0];
    o = (l == 4'h9) ? 3'd1 : (l == 4'hB) ? 3'd2 : (l == 4'h4) ? 3'd3 :
        (l == 4'h8) ? 3'd4 : (l == 4'h7) ? 3'd5 : 3'd0;
    if (!pg) begin
      if (b == 8'hA7) return {1'b0, 4'd1, 3'd6, 2'd1, 4'd2};
      if (b == 8'hAF) return {1'b0, 4'd1, 3'd7, 2'd1, 4'd2};
      if (o inside {3'd1, 3'd2, 3'd3}) begin
        case (h)
          4'hA: return {1'b0, 4'd1, o, 2'd1, 4'd2};
          4'hB: return {1'b0, 4'd2, o, 2'd1, 4'd3};
          4'hC: return {1'b0, 4'd3, o, 2'd2, 4'd4};
          4'hD: return {1'b0, 4'd4, o, 2'd2, 4'd4};
          4'hE: return {1'b0, 4'd5, o, 2'd1, 4'd3};
          4'hF: return {1'b0, 4'd6, o, 2'd0, 4'd2};
          default: ;
        endcase
      end
      if (o inside {3'd4, 3'd5}) begin
        case (h)
          4'h3: return {1'b0, 4'd2, o, 2'd1, 4'd4};
          4'h4: return {1'b0, 4'd9, o, 2'd0, 4'd1};
          4'h5: return {1'b0, 4'd10, o, 2'd0, 4'd1};
          4'h6: return {1'b0, 4'd5, o, 2'd1, 4'd4};
          4'h7: return {1'b0, 4'd6, o, 2'd0, 4'd3};
          default: ;
        endcase
      end
    end else begin
      if (o inside {3'd1, 3'd2, 3'd3} && h == 4'hE) return {1'b0, 4'd7, o, 2'd1, 4'd4};
      if (o inside {3'd1, 3'd2, 3'd3} && h == 4'hD) return {1'b0, 4'd8, o, 2'd2, 4'd5};
      if (o inside {3'd4, 3'd5} && h == 4'h6)       return {1'b0, 4'd7, o, 2'd1, 4'd5};
    end
    return {1'b1, 4'd0, 3'd0, 2'd0, 4'd0};
  endfunction

  function automatic string tag_of(input bit pg, input logic [13:0] r);
    if (r[13])                   return "R9";
    if (pg)                      return "R8";
    if (r[8:6] >= 3'd6)          return "R7";
    if (r[8:6] >= 3'd4)          return "R6";
    return "R4/R5";
  endfunction

  function automatic logic [13:0] outs();
    return {dec_illegal, dec_mode, dec_op, dec_len, dec_cycles};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one byte at a falling edge, check at the next falling edge.
  task automatic send(input logic [7:0] b);
    logic [13:0] exp, prev;
    bit was_pend;
    prev = outs();
    was_pend = model_pend;
    in_vld  = 1'b1;
    in_byte = b;
    @(negedge clk);
    in_vld = 1'b0;
    if (!was_pend && b == 8'h9E) begin
      model_pend = 1'b1;
      chk(dec_vld == 1'b0, "R3", 16'(dec_vld), 16'd0);
      chk(outs() == prev, "R3", 16'(outs()), 16'(prev));
    end else begin
      model_pend = 1'b0;
      exp = ref_dec(was_pend, b);
      chk(dec_vld == 1'b1, "R2", 16'(dec_vld), 16'd1);
      chk(outs() == exp, tag_of(was_pend, exp), 16'(outs()), 16'(exp));
    end
  endtask

  task automatic idle(input int n);
    logic [13:0] prev;
    for (int i = 0; i < n; i++) begin
      prev = outs();
      @(negedge clk);
      chk(dec_vld == 1'b0, "R2", 16'(dec_vld), 16'd0);
      chk(outs() == prev, "R10", 16'(outs()), 16'(prev));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] b;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(dec_vld == 1'b0, "R1", 16'(dec_vld), 16'd0);
    chk(outs() == 14'd0, "R1", 16'(outs()), 16'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(outs() == 14'd0 && !dec_vld, "R1", 16'(outs()), 16'd0);

    // directed corners
    send(8'hA9); send(8'hBB); send(8'hC4); send(8'hD9); send(8'hEB); send(8'hF4); // R4 R5
    send(8'h38); send(8'h47); send(8'h58); send(8'h67); send(8'h78);              // R6
    send(8'hA7); send(8'hAF);                                                      // R7
    send(8'h9E); idle(5); send(8'hE9);                                             // R3 R8
    send(8'h9E); send(8'hDB); send(8'h9E); send(8'h68);                            // R8
    send(8'h9E); send(8'h9E);                                                      // R9 double page
    send(8'hA9);                                                                   // R9 pending cleared
    send(8'h9E); send(8'hA9);                                                      // R9 paged unlisted
    send(8'h00); send(8'h87); send(8'hFF);                                         // R9
    idle(3);                                                                       // R10

    // constrained random
    for (int n = 0; n < 2000; n++) begin
      case ($urandom_range(0, 3))
        0: b = 8'h9E;
        1: b = {4'($urandom_range(10, 15)), 4'(($urandom_range(0, 2) == 0) ? 4'h9 :
                                                ($urandom_range(0, 1) == 0) ? 4'hB : 4'h4)};
        2: b = {4'($urandom_range(3, 7)), ($urandom_range(0, 1) == 0) ? 4'h8 : 4'h7};
        default: b = 8'($urandom);
      endcase
      send(b);
      if ($urandom_range(0, 4) == 0) idle($urandom_range(1, 3));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule